// File: doc/BRIEF.md
# Serial Controller Register and Interrupt Front End

This block is the software-visible side of a simple byte-oriented serial port. A processor reaches it through a 32-bit, byte-addressed request bus with a 256-byte window. Inside it holds control words for line setup, interrupt enables, FIFO management and the baud divisor. It also holds a read-only line status word and a set of sticky interrupt flags. Two 16-entry byte FIFOs sit between the bus and the line logic. Bytes written by software drain out of a valid/ready stream toward a transmitter. Bytes arriving on an input stream queue up until software reads them.

Each data register acts on one byte lane only, the most significant. The bus numbers its lanes big-endian: byte enable bit 0 selects bits 31:24. Interrupt flags are cleared by writing zeros into them, and a flag whose condition still holds comes straight back. A single level interrupt output is raised while any enabled flag is set. The serial line itself, flow control and DMA movement are handled elsewhere, or not at all.

Top module: `sio_regfront`

## Requirements
- R1: After reset the line control word reads 0x40000000 and the baud divisor reads 0x03FF0000. Interrupt enable, FIFO control and line status read zero, both FIFOs are empty, and `irq`, `tx_out_valid` and `bus_rdata` are low. From the first clock after reset the interrupt status word reads 0x00020000, because the transmit FIFO is empty.
- R2: Word index = `bus_addr`>>2. Index 0 is line control (mask 0xE17F0000), 1 is line status (read-only), 2 is interrupt enable (mask 0x000F0000), 3 is interrupt status, 4 is FIFO control (mask 0x001F0000) and 5 is baud divisor (mask 0x03FF0000). Index 8 is transmit data and 12 is receive data. A write replaces only the enabled lanes, and the merged word is then ANDed with the mask. Every other index reads zero and ignores writes, and the transmit data register reads zero.
- R3: A read returns its data on `bus_rdata` in the cycle after the request. Lanes whose `bus_ben` bit is clear read zero, where `bus_ben[0]` is bits 31:24 and `bus_ben[3]` is bits 7:0. In any cycle that follows a cycle with no read request, `bus_rdata` is zero.
- R4: The interrupt status word holds three flags: bit 16 receive data ready, bit 17 transmit FIFO empty, bit 18 error. A write ANDs each enabled lane with the written byte, so only a written 0 clears a flag. A flag whose set condition holds in the cycle of the write stays set.
- R5: The receive-ready flag is set in the cycle after the receive FIFO is non-empty. The transmit-empty flag is set in the cycle after the transmit FIFO is empty. Both flags stay set until software clears them.
- R6: `irq` is high exactly when some status bit among 18:16 is set while the enable bit in the same position is set.
- R7: A write to transmit data with `bus_ben[0]` set pushes `bus_wdata[31:24]`, and writes without that lane push nothing. The FIFO head appears on `tx_out_data` with `tx_out_valid` while the FIFO is non-empty. Bytes leave in push order, and a byte is removed on a cycle with both valid and ready.
- R8: A read of receive data with `bus_ben[0]` set pops the oldest byte and returns it in bits 31:24, with zero elsewhere. If the FIFO is empty the read returns zero and pops nothing. A read without that lane returns zero and pops nothing.
- R9: Each FIFO holds 16 bytes. A push into a full FIFO, from either the bus or `rx_in_valid`, is dropped. The drop sets line status bit 0, which stays set until reset, and it also sets the error flag.
- R10: FIFO control bit 16 enables resets, bit 17 empties the receive FIFO and bit 18 empties the transmit FIFO. A reset bit acts only in a write whose resulting word also has bit 16 set.
- R11: Interrupt enable bit 19 is stored and read back, but it has no effect on FIFO movement or on `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Single-cycle bus request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the window |
| bus_ben | input | 4 | Byte lane enables, bit 0 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt |
| tx_out_valid | output | 1 | Transmit byte available |
| tx_out_data | output | 8 | Transmit byte |
| tx_out_ready | input | 1 | Downstream accepts the transmit byte |
| rx_in_valid | input | 1 | Received byte present this cycle |
| rx_in_data | input | 8 | Received byte |

## Verification
A corrupted flag or enable shows at `irq` in the cycle after the fault. It also appears in the next status read, which lands one cycle after its request. A wrong FIFO pointer or count shows first as reordered, duplicated or missing bytes on `tx_out_data` or in receive reads. It also shows as a status bit that sets too early or not at all. The stimulus therefore reads flags after their set conditions change and drains both FIFOs completely, including across an overflow. It also follows each FIFO reset with a read or stream check, so a fault surfaces within a few cycles of its cause.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [3:0] {
        SEL_LCTL,
        SEL_LSTAT,
        SEL_IEN,
        SEL_ISTAT,
        SEL_FCTL,
        SEL_BDIV,
        SEL_TXD,
        SEL_RXD,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     req;
        logic     wr;
        reg_sel_e sel;
        lane_t    ben;
        word_t    wdata;
    } bus_cmd_t;

    // word indices inside the window
    localparam int IDX_LCTL  = 0;
    localparam int IDX_LSTAT = 1;
    localparam int IDX_IEN   = 2;
    localparam int IDX_ISTAT = 3;
    localparam int IDX_FCTL  = 4;
    localparam int IDX_BDIV  = 5;
    localparam int IDX_TXD   = 8;
    localparam int IDX_RXD   = 12;

    // writable-bit masks and reset images
    localparam word_t MASK_LCTL  = 32'hE17F_0000;
    localparam word_t MASK_IEN   = 32'h000F_0000;
    localparam word_t MASK_FCTL  = 32'h001F_0000;
    localparam word_t MASK_BDIV  = 32'h03FF_0000;
    localparam word_t MASK_ISTAT = 32'h0007_0000;
    localparam word_t RST_LCTL   = 32'h4000_0000;
    localparam word_t RST_BDIV   = 32'h03FF_0000;

    // bit positions
    localparam int FLAG_RX   = 16;
    localparam int FLAG_TX   = 17;
    localparam int FLAG_ERR  = 18;
    localparam int IEN_DMA   = 19;
    localparam int FC_EN     = 16;
    localparam int FC_RXRST  = 17;
    localparam int FC_TXRST  = 18;
    localparam int LS_OVF    = 0;

    // plain masked control registers, built by a generate loop
    localparam int N_PLAIN    = 4;
    localparam int PIDX_LCTL  = 0;
    localparam int PIDX_IEN   = 1;
    localparam int PIDX_FCTL  = 2;
    localparam int PIDX_BDIV  = 3;
    localparam reg_sel_e PLAIN_SEL  [N_PLAIN] = '{SEL_LCTL, SEL_IEN, SEL_FCTL, SEL_BDIV};
    localparam word_t    PLAIN_MASK [N_PLAIN] = '{MASK_LCTL, MASK_IEN, MASK_FCTL, MASK_BDIV};
    localparam word_t    PLAIN_RST  [N_PLAIN] = '{RST_LCTL, 32'h0, 32'h0, RST_BDIV};

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] addr);
        logic [ADDR_W-1:0] idx;
        idx = addr >> 2;
        case (int'(idx))
            IDX_LCTL:  return SEL_LCTL;
            IDX_LSTAT: return SEL_LSTAT;
            IDX_IEN:   return SEL_IEN;
            IDX_ISTAT: return SEL_ISTAT;
            IDX_FCTL:  return SEL_FCTL;
            IDX_BDIV:  return SEL_BDIV;
            IDX_TXD:   return SEL_TXD;
            IDX_RXD:   return SEL_RXD;
            default:   return SEL_NONE;
        endcase
    endfunction

    // expand lane enables into a bit mask (lane 0 = most significant byte)
    function automatic word_t lane_bits(input lane_t ben);
        word_t m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            m[DATA_W-1-BYTE_W*i -: BYTE_W] = {BYTE_W{ben[i]}};
        end
        return m;
    endfunction

    function automatic word_t lane_merge(input word_t old, input word_t wd, input lane_t ben);
        word_t m;
        m = lane_bits(ben);
        return (old & ~m) | (wd & m);
    endfunction

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[wr_ptr_q] <= din;
    end

endmodule

// File: rtl/sio_maskreg.sv
module sio_maskreg import sio_pkg::*; #(
    parameter word_t MASK = '0,
    parameter word_t RSTV = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  lane_t ben,
    input  word_t wdata,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RSTV & MASK;
        else if (wr) q <= lane_merge(q, wdata, ben) & MASK;
    end
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank import sio_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  bus_cmd_t cmd,
    input  logic     rx_nonempty,
    input  logic     tx_empty,
    input  logic     ovf_evt,
    output word_t    lctl_q,
    output word_t    lstat_q,
    output word_t    ien_q,
    output word_t    istat_q,
    output word_t    fctl_q,
    output word_t    bdiv_q,
    output logic     rx_clr,
    output logic     tx_clr,
    output logic     irq
);
    word_t plain_q [N_PLAIN];
    logic  wr_any;
    logic  fc_wr;
    word_t fc_next;
    word_t istat_d;

    assign wr_any = cmd.req && cmd.wr;

    for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
        sio_maskreg #(
            .MASK (PLAIN_MASK[g]),
            .RSTV (PLAIN_RST[g])
        ) u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_any && (cmd.sel == PLAIN_SEL[g])),
            .ben   (cmd.ben),
            .wdata (cmd.wdata),
            .q     (plain_q[g])
        );
    end

    assign lctl_q = plain_q[PIDX_LCTL];
    assign ien_q  = plain_q[PIDX_IEN];
    assign fctl_q = plain_q[PIDX_FCTL];
    assign bdiv_q = plain_q[PIDX_BDIV];

    // FIFO resets look at the word as it stands after this write
    assign fc_wr   = wr_any && (cmd.sel == SEL_FCTL);
    assign fc_next = lane_merge(fctl_q, cmd.wdata, cmd.ben) & MASK_FCTL;
    assign rx_clr  = fc_wr && fc_next[FC_EN] && fc_next[FC_RXRST];
    assign tx_clr  = fc_wr && fc_next[FC_EN] && fc_next[FC_TXRST];

    // status flags: software clear first, hardware set wins
    always_comb begin
        istat_d = istat_q;
        if (wr_any && (cmd.sel == SEL_ISTAT)) begin
            istat_d = istat_q & (~lane_bits(cmd.ben) | cmd.wdata) & MASK_ISTAT;
        end
        if (rx_nonempty) istat_d[FLAG_RX]  = 1'b1;
        if (tx_empty)    istat_d[FLAG_TX]  = 1'b1;
        if (ovf_evt)     istat_d[FLAG_ERR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) istat_q <= '0;
        else     istat_q <= istat_d;
    end

    always_ff @(posedge clk) begin
        if (rst)          lstat_q <= '0;
        else if (ovf_evt) lstat_q[LS_OVF] <= 1'b1;
    end

    assign irq = |(istat_q[FLAG_ERR:FLAG_RX] & ien_q[FLAG_ERR:FLAG_RX]);

endmodule

// File: rtl/sio_regfront.sv
module sio_regfront import sio_pkg::*; #(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_ben,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              tx_out_valid,
    output logic [BYTE_W-1:0] tx_out_data,
    input  logic              tx_out_ready,
    input  logic              rx_in_valid,
    input  logic [BYTE_W-1:0] rx_in_data
);
    bus_cmd_t cmd;
    word_t    lctl_q, lstat_q, ien_q, istat_q, fctl_q, bdiv_q;
    logic     rx_clr, tx_clr;
    logic     tx_push_req, tx_pop, tx_empty, tx_full;
    logic     rx_pop_req, rx_empty, rx_full;
    byte_t    rx_head;
    logic     ovf_evt;
    word_t    rd_word;
    word_t    rdata_q;

    assign cmd.req   = bus_req;
    assign cmd.wr    = bus_wr;
    assign cmd.sel   = decode(bus_addr);
    assign cmd.ben   = bus_ben;
    assign cmd.wdata = bus_wdata;

    assign tx_push_req = cmd.req && cmd.wr && (cmd.sel == SEL_TXD) && cmd.ben[0];
    assign rx_pop_req  = cmd.req && !cmd.wr && (cmd.sel == SEL_RXD) && cmd.ben[0];
    assign ovf_evt     = (tx_push_req && tx_full) || (rx_in_valid && rx_full);

    sio_regbank u_regs (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .rx_nonempty (!rx_empty),
        .tx_empty    (tx_empty),
        .ovf_evt     (ovf_evt),
        .lctl_q      (lctl_q),
        .lstat_q     (lstat_q),
        .ien_q       (ien_q),
        .istat_q     (istat_q),
        .fctl_q      (fctl_q),
        .bdiv_q      (bdiv_q),
        .rx_clr      (rx_clr),
        .tx_clr      (tx_clr),
        .irq         (irq)
    );

    sio_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .clr   (tx_clr),
        .push  (tx_push_req),
        .din   (cmd.wdata[DATA_W-1 -: BYTE_W]),
        .pop   (tx_pop),
        .dout  (tx_out_data),
        .empty (tx_empty),
        .full  (tx_full)
    );

    assign tx_out_valid = !tx_empty;
    assign tx_pop       = tx_out_valid && tx_out_ready;

    sio_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .clr   (rx_clr),
        .push  (rx_in_valid),
        .din   (rx_in_data),
        .pop   (rx_pop_req),
        .dout  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    always_comb begin
        case (cmd.sel)
            SEL_LCTL:  rd_word = lctl_q;
            SEL_LSTAT: rd_word = lstat_q;
            SEL_IEN:   rd_word = ien_q;
            SEL_ISTAT: rd_word = istat_q;
            SEL_FCTL:  rd_word = fctl_q;
            SEL_BDIV:  rd_word = bdiv_q;
            SEL_RXD:   rd_word = (rx_pop_req && !rx_empty) ? {rx_head, {(DATA_W-BYTE_W){1'b0}}} : '0;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                    rdata_q <= '0;
        else if (cmd.req && !cmd.wr) rdata_q <= rd_word & lane_bits(cmd.ben);
        else                        rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk import sio_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              tx_out_valid,
    input logic              tx_out_ready,
    input logic [BYTE_W-1:0] tx_out_data,
    input logic [2:0]        istat_flags,
    input logic [2:0]        ien_flags,
    input logic              ls_ovf,
    input logic              rx_empty,
    input logic              tx_clr
);
    a_r3_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_wr) |=> (bus_rdata == '0));

    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wr && (decode(bus_addr) == SEL_RXD) && rx_empty) |=> (bus_rdata == '0));

    a_r5_rx_flag_sets: assert property (@(posedge clk) disable iff (rst)
        !rx_empty |=> istat_flags[0]);

    a_r5_tx_flag_sets: assert property (@(posedge clk) disable iff (rst)
        !tx_out_valid |=> istat_flags[1]);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ls_ovf |=> ls_ovf);

    a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (ien_flags == 3'b000) |-> !irq);

    a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> (istat_flags != 3'b000));

    a_r7_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_out_valid && !tx_out_ready && !tx_clr) |=> (tx_out_valid && $stable(tx_out_data)));

endmodule

bind sio_regfront sio_regfront_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_req      (bus_req),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .irq          (irq),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .tx_out_data  (tx_out_data),
    .istat_flags  (istat_q[18:16]),
    .ien_flags    (ien_q[18:16]),
    .ls_ovf       (lstat_q[0]),
    .rx_empty     (rx_empty),
    .tx_clr       (tx_clr)
);

// File: tb/test_sio_regfront.sv
module test_sio_regfront;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 18;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [3:0]  ben;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    // masked writes, lane selection, read-only and unused offsets (R2, R3)
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 8'h00, 4'hF, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 8'h00, 4'hF, 32'h0,         32'hE17F_0000},
        '{1'b1, 8'h00, 4'h1, 32'h0000_0000, 32'h0},
        '{1'b0, 8'h00, 4'hF, 32'h0,         32'h007F_0000},
        '{1'b1, 8'h08, 4'hF, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 8'h08, 4'hF, 32'h0,         32'h000F_0000},
        '{1'b1, 8'h14, 4'h2, 32'h00AB_0000, 32'h0},
        '{1'b0, 8'h14, 4'hF, 32'h0,         32'h03AB_0000},
        '{1'b0, 8'h14, 4'h1, 32'h0,         32'h0300_0000},
        '{1'b1, 8'h04, 4'hF, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 8'h04, 4'hF, 32'h0,         32'h0000_0000},
        '{1'b1, 8'h40, 4'hF, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 8'h40, 4'hF, 32'h0,         32'h0000_0000},
        '{1'b0, 8'h20, 4'hF, 32'h0,         32'h0000_0000},
        '{1'b1, 8'h10, 4'hF, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 8'h10, 4'hF, 32'h0,         32'h001F_0000},
        '{1'b0, 8'h0C, 4'h4, 32'h0,         32'h0000_0000},
        '{1'b0, 8'h0C, 4'hF, 32'h0,         32'h0002_0000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_req, bus_wr;
    logic [7:0]  bus_addr;
    logic [3:0]  bus_ben;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq, tx_out_valid, tx_out_ready, rx_in_valid;
    logic [7:0]  tx_out_data, rx_in_data;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_regfront i_sio_regfront (
        .clk          (clk),
        .rst          (rst),
        .bus_req      (bus_req),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_ben      (bus_ben),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq          (irq),
        .tx_out_valid (tx_out_valid),
        .tx_out_data  (tx_out_data),
        .tx_out_ready (tx_out_ready),
        .rx_in_valid  (rx_in_valid),
        .rx_in_data   (rx_in_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_ben = be; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_ben = be;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [3:0] be, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, be, d);
        chk(tag, d, exp);
    endtask

    task automatic rx_push(input logic [7:0] b);
        rx_in_valid = 1'b1; rx_in_data = b;
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_ben = '0;
        bus_wdata = '0; tx_out_ready = 1'b0; rx_in_valid = 1'b0; rx_in_data = '0;
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 tx_valid", {31'b0, tx_out_valid}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd_chk("R1 lctl", 8'h00, 4'hF, 32'h4000_0000);
        rd_chk("R1 bdiv", 8'h14, 4'hF, 32'h03FF_0000);
        rd_chk("R1 ien",  8'h08, 4'hF, 32'h0);
        rd_chk("R1 fctl", 8'h10, 4'hF, 32'h0);
        rd_chk("R1 lstat", 8'h04, 4'hF, 32'h0);
        rd_chk("R1 istat", 8'h0C, 4'hF, 32'h0002_0000);
        rd_chk("R8 empty rx", 8'h30, 4'h1, 32'h0);

        for (int i = 0; i < N_VEC; i++) begin
            if (VECS[i].we) wr(VECS[i].addr, VECS[i].ben, VECS[i].wd);
            else rd_chk($sformatf("R2 R3 vec%0d", i), VECS[i].addr, VECS[i].ben, VECS[i].exp);
        end

        // R4: clearing the tx flag while its condition holds leaves it set
        wr(8'h08, 4'hF, 32'h0);
        chk("R6 irq off", {31'b0, irq}, 32'h0);
        wr(8'h0C, 4'h2, 32'h0000_0000);
        rd_chk("R4 set wins", 8'h0C, 4'hF, 32'h0002_0000);

        // R7: only lane 0 pushes
        wr(8'h20, 4'h2, 32'h0055_0000);
        chk("R7 no push", {31'b0, tx_out_valid}, 32'h0);
        wr(8'h20, 4'h1, 32'hA500_0000);
        chk("R7 valid", {31'b0, tx_out_valid}, 32'h1);
        chk("R7 data", {24'b0, tx_out_data}, 32'hA5);
        wr(8'h0C, 4'h2, 32'h00FD_0000);
        rd_chk("R4 clear tx flag", 8'h0C, 4'hF, 32'h0);
        tx_out_ready = 1'b1;
        @(negedge clk);
        tx_out_ready = 1'b0;
        chk("R7 drained", {31'b0, tx_out_valid}, 32'h0);
        idle(1);
        rd_chk("R5 tx flag back", 8'h0C, 4'hF, 32'h0002_0000);

        // R6: enable masking
        wr(8'h08, 4'hF, 32'h0002_0000);
        chk("R6 irq tx", {31'b0, irq}, 32'h1);
        wr(8'h08, 4'hF, 32'h0001_0000);
        chk("R6 irq rx none", {31'b0, irq}, 32'h0);
        rx_push(8'h3C);
        idle(1);
        chk("R5 R6 irq rx", {31'b0, irq}, 32'h1);
        rd_chk("R8 pop", 8'h30, 4'h1, 32'h3C00_0000);
        rd_chk("R8 empty", 8'h30, 4'h1, 32'h0);
        idle(1);
        chk("R5 sticky", {31'b0, irq}, 32'h1);
        wr(8'h0C, 4'h2, 32'h00FE_0000);
        chk("R4 rx clear", {31'b0, irq}, 32'h0);

        // R8: other lanes do not pop
        rx_push(8'h77);
        rd_chk("R8 lane1", 8'h30, 4'h2, 32'h0);
        rd_chk("R8 all lanes", 8'h30, 4'hF, 32'h7700_0000);
        rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
        rd_chk("R8 order1", 8'h30, 4'h1, 32'h1100_0000);
        rd_chk("R8 order2", 8'h30, 4'h1, 32'h2200_0000);
        rd_chk("R8 order3", 8'h30, 4'h1, 32'h3300_0000);

        // R9: overflow
        rx_in_valid = 1'b1;
        for (int i = 0; i < 17; i++) begin
            rx_in_data = 8'h80 + 8'(i);
            @(negedge clk);
        end
        rx_in_valid = 1'b0;
        idle(1);
        rd_chk("R9 lstat", 8'h04, 4'hF, 32'h0000_0001);
        rd_chk("R9 error flag", 8'h0C, 4'hF, 32'h0007_0000);
        for (int i = 0; i < 16; i++) begin
            rd(8'h30, 4'h1, d);
            chk($sformatf("R9 byte%0d", i), d, {8'h80 + 8'(i), 24'h0});
        end
        rd_chk("R9 dropped", 8'h30, 4'h1, 32'h0);
        wr(8'h08, 4'hF, 32'h0004_0000);
        chk("R6 irq err", {31'b0, irq}, 32'h1);
        wr(8'h0C, 4'h2, 32'h00FB_0000);
        chk("R4 err clear", {31'b0, irq}, 32'h0);
        rd_chk("R9 lstat sticky", 8'h04, 4'hF, 32'h0000_0001);

        // R10: reset gating
        rx_push(8'hAA); rx_push(8'hBB);
        wr(8'h10, 4'hF, 32'h0002_0000);
        rd_chk("R10 no enable", 8'h30, 4'h1, 32'hAA00_0000);
        wr(8'h10, 4'hF, 32'h0003_0000);
        rd_chk("R10 rx reset", 8'h30, 4'h1, 32'h0);
        wr(8'h20, 4'h1, 32'h0100_0000);
        wr(8'h20, 4'h1, 32'h0200_0000);
        wr(8'h10, 4'hF, 32'h0004_0000);
        chk("R10 tx kept", {31'b0, tx_out_valid}, 32'h1);
        chk("R10 tx head", {24'b0, tx_out_data}, 32'h01);
        wr(8'h10, 4'hF, 32'h0005_0000);
        chk("R10 tx reset", {31'b0, tx_out_valid}, 32'h0);
        rd_chk("R10 fctl", 8'h10, 4'hF, 32'h0005_0000);

        // R11: DMA enable stored, no effect
        wr(8'h08, 4'hF, 32'h0008_0000);
        rd_chk("R11 ien", 8'h08, 4'hF, 32'h0008_0000);
        wr(8'h20, 4'h1, 32'h5A00_0000);
        chk("R11 tx push", {24'b0, tx_out_data}, 32'h5A);
        chk("R11 valid", {31'b0, tx_out_valid}, 32'h1);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        tx_out_ready = 1'b1;
        @(negedge clk);
        tx_out_ready = 1'b0;
        chk("R11 drained", {31'b0, tx_out_valid}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule